// File: doc/BRIEF.md
# Cascadable Range Counter

The block is a chain of small up-counting stages. Each stage holds a `W`-bit value and has its own lower and upper bound. Once the value reaches the upper bound on an enabled cycle, the stage reloads the lower bound instead of incrementing. That reload goes through the stage's parallel-load path. The stage's reset path is not involved. When the lower bound is zero and the upper bound is m−1, the stage becomes a modulo-m counter. When the bounds are 0 and 15, the stage counts plainly modulo 16.

Each stage raises an enable-gated wrap flag. That flag is the count enable of the next stage up, so the stages ripple like the digits of a mixed-radix number. With the default two 4-bit stages and full-range bounds, the chain forms a modulo-256 counter. The wrap flag of the last stage is the block's `tc` output. A synchronous clear has priority over everything. An internal reload has priority over incrementing. When the count enable is low, every stage holds.

Top module: `span_counter`

## Requirements
- R1: When `clr` is 1 at a clock edge, every bit of `q` is 0 after that edge, whatever `cnt` and the bounds are.
- R2: When `clr` is 0 and `cnt` is 0, `q` keeps its value across the edge.
- R3: When stage 0 is enabled (`cnt` = 1, `clr` = 0) and its value is not at its wrap point, its value becomes (value + 1) mod 2^W.
- R4: Stage k uses `lo_bound[k*W +: W]` and `hi_bound[k*W +: W]`. When lo < hi for a stage and the stage is enabled with value equal to hi, the stage loads lo. For example, the bounds 5 and 11 give 5,6,…,11,5.
- R5: Bounds lo = 0 and hi = m−1 make a stage count modulo m. For example, m = 6 gives 0..5 and then 0.
- R6: The wrap point of a stage is hi when lo < hi, and all-ones otherwise. A stage's wrap flag is 1 exactly when the stage is enabled and its value equals its wrap point. `tc` is the wrap flag of the last stage and is combinational from `q`, `cnt` and the bounds.
- R7: Stage 0 is enabled by `cnt`, and stage k+1 is enabled by the wrap flag of stage k. A stage that is not enabled holds. With every stage at lo = 0 and hi = 15, `q` counts modulo 256, and stage 1 occupies `q[7:4]`.
- R8: When lo ≥ hi for a stage, no reload happens, and the stage counts plainly modulo 2^W.
- R9: After a clear, a stage starts at 0 even when lo > 0. It counts up to hi before its first reload to lo.
- R10: Holding `cnt` at 0 while a stage sits at hi keeps the value at hi, with no reload.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| clr | input | 1 | Synchronous clear, highest priority |
| cnt | input | 1 | Count enable of stage 0 |
| lo_bound | input | STAGES*W | Reload value of each stage, stage k in bits k*W +: W |
| hi_bound | input | STAGES*W | Upper bound of each stage, same packing |
| q | output | STAGES*W | Registered counter value, stage 0 in the low bits |
| tc | output | 1 | Enable-gated wrap flag of the last stage |

## Verification
The properties assume the bounds are steady across each enabled edge. Any property that reasons about a reload also assumes that a stage's lo and hi are a legal pair with lo below hi. The stimulus changes the bounds only right after a clear or while the count is paused. It exercises legal configurations (full range, 5 to 11, modulo 6) and one reversed pair, which is used only to confirm that the stage falls back to the plain modulo-16 count. The clear is held for the first edges, so no property sees unknown state.

// File: rtl/span_pkg.sv
package span_pkg;
  // Per-stage control decided by the wrap comparator.
  typedef struct packed {
    logic ld;   // reload the lower bound
    logic inc;  // advance by one
  } step_t;
endpackage

// File: rtl/span_wrap_cmp.sv
module span_wrap_cmp
  import span_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] val,
  input  logic [W-1:0] lo,
  input  logic [W-1:0] hi,
  input  logic         en,
  output step_t        ctl,
  output logic         wrap
);
  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

  logic         legal;
  logic [W-1:0] top_val;
  logic         at_top;

  always_comb begin
    legal   = (lo < hi);
    top_val = legal ? hi : ALL_ONES;
    at_top  = (val == top_val);
    wrap    = en & at_top;
    ctl.ld  = wrap & legal;
    ctl.inc = en & ~ctl.ld;
  end
endmodule

// File: rtl/span_stage.sv
module span_stage
  import span_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         clr,
  input  step_t        ctl,
  input  logic [W-1:0] lo,
  output logic [W-1:0] val
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (clr)          val <= '0;
    else if (ctl.ld)  val <= lo;
    else if (ctl.inc) val <= val + ONE;
  end
endmodule

// File: rtl/span_counter.sv
module span_counter
  import span_pkg::*;
#(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic                  clk,
  input  logic                  clr,
  input  logic                  cnt,
  input  logic [STAGES*W-1:0]   lo_bound,
  input  logic [STAGES*W-1:0]   hi_bound,
  output logic [STAGES*W-1:0]   q,
  output logic                  tc
);
  localparam int TW = STAGES * W;

  logic [STAGES:0] en_chain;

  assign en_chain[0] = cnt;

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    step_t        ctl;
    logic [W-1:0] val;

    span_wrap_cmp #(.W(W)) u_cmp (
      .val  (val),
      .lo   (lo_bound[k*W +: W]),
      .hi   (hi_bound[k*W +: W]),
      .en   (en_chain[k]),
      .ctl  (ctl),
      .wrap (en_chain[k+1])
    );

    span_stage #(.W(W)) u_reg (
      .clk (clk),
      .clr (clr),
      .ctl (ctl),
      .lo  (lo_bound[k*W +: W]),
      .val (val)
    );

    assign q[k*W +: W] = val;
  end

  assign tc = en_chain[STAGES];

  logic [TW-1:0] unused_width_probe;
  assign unused_width_probe = q;
endmodule

// File: rtl/span_counter_chk.sv
module span_counter_chk #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input logic                clk,
  input logic                clr,
  input logic                cnt,
  input logic [STAGES*W-1:0] lo_bound,
  input logic [STAGES*W-1:0] hi_bound,
  input logic [STAGES*W-1:0] q,
  input logic                tc
);
  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};
  localparam logic [W-1:0] ONE      = {{(W-1){1'b0}}, 1'b1};

  logic primed = 1'b0;
  always_ff @(posedge clk) primed <= 1'b1;

  logic [W-1:0] q0, lo0, hi0, top0;
  logic         legal0;
  assign q0     = q[W-1:0];
  assign lo0    = lo_bound[W-1:0];
  assign hi0    = hi_bound[W-1:0];
  assign legal0 = lo0 < hi0;
  assign top0   = legal0 ? hi0 : ALL_ONES;

  // R1: clear wins over every other input
  assert_clear_R1: assert property (@(posedge clk) disable iff (!primed)
    clr |=> (q == '0));

  // R2 / R10: disabled chain holds
  assert_hold_R2: assert property (@(posedge clk) disable iff (!primed || clr)
    (!cnt) |=> $stable(q));

  // R3: stage 0 steps by one away from its wrap point
  assert_step_R3: assert property (@(posedge clk) disable iff (!primed || clr)
    (cnt && q0 != top0) |=> (q0 == $past(q0) + ONE));

  // R4: legal range reloads the lower bound at hi
  assert_wrap_R4: assert property (@(posedge clk) disable iff (!primed || clr)
    (cnt && legal0 && q0 == hi0) |=> (q0 == $past(lo0)));

  // R6: terminal count needs the enable
  assert_tc_gated_R6: assert property (@(posedge clk) disable iff (!primed)
    (!cnt) |-> !tc);

  // R8: reversed bounds fall back to a plain wrap
  assert_plain_R8: assert property (@(posedge clk) disable iff (!primed || clr)
    (cnt && !legal0 && q0 == ALL_ONES) |=> (q0 == '0));

  if (STAGES > 1) begin : g_upper
    // R7: stage 1 moves only when stage 0 wraps
    assert_upper_idle_R7: assert property (@(posedge clk) disable iff (!primed || clr)
      !(cnt && q0 == top0) |=> $stable(q[2*W-1:W]));
  end
endmodule

bind span_counter span_counter_chk #(.W(W), .STAGES(STAGES)) u_chk (
  .clk(clk), .clr(clr), .cnt(cnt), .lo_bound(lo_bound),
  .hi_bound(hi_bound), .q(q), .tc(tc)
);

// File: tb/span_counter_tb.sv
`timescale 1ns/1ps
module span_counter_tb;
  localparam int W  = 4;
  localparam int S  = 2;
  localparam int TW = W * S;

  logic          clk = 1'b0;
  logic          clr = 1'b1;
  logic          cnt = 1'b0;
  logic [TW-1:0] lo_bound = '0;
  logic [TW-1:0] hi_bound = '1;
  logic [TW-1:0] q;
  logic          tc;

  always #10 clk = ~clk;  // 50 MHz

  span_counter #(.W(W), .STAGES(S)) u_dut (
    .clk(clk), .clr(clr), .cnt(cnt), .lo_bound(lo_bound),
    .hi_bound(hi_bound), .q(q), .tc(tc)
  );

  int checks = 0;
  int errors = 0;
  logic [TW-1:0] mq = '0;
  logic [TW:0]   exp_q[$];
  string         exp_tag[$];
  bit            done = 0;

  function automatic logic [W-1:0] wrap_of(input int k);
    logic [W-1:0] lo, hi;
    lo = lo_bound[k*W +: W];
    hi = hi_bound[k*W +: W];
    return (lo < hi) ? hi : {W{1'b1}};
  endfunction

  task automatic step(input logic c_clr, input logic c_cnt, input string tag);
    logic en, t;
    logic [TW-1:0] nq;
    @(negedge clk);
    clr = c_clr;
    cnt = c_cnt;
    en = c_cnt;
    nq = mq;
    for (int k = 0; k < S; k++) begin
      logic [W-1:0] v, lo, hi;
      v  = mq[k*W +: W];
      lo = lo_bound[k*W +: W];
      hi = hi_bound[k*W +: W];
      t  = en && (v == wrap_of(k));
      if (c_clr)                nq[k*W +: W] = '0;
      else if (t && (lo < hi))  nq[k*W +: W] = lo;
      else if (en)              nq[k*W +: W] = v + 1'b1;
      en = t;
    end
    mq = nq;
    en = c_cnt;
    for (int k = 0; k < S; k++) en = en && (mq[k*W +: W] == wrap_of(k));
    exp_q.push_back({en, mq});
    exp_tag.push_back(tag);
    @(posedge clk);
    #6;
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #5;
      if (exp_q.size() > 0) begin
        logic [TW:0] e;
        string tg;
        e  = exp_q.pop_front();
        tg = exp_tag.pop_front();
        checks++;
        if (q !== e[TW-1:0]) begin
          errors++;
          $display("FAIL %s q: actual=%0d expected=%0d", tg, q, e[TW-1:0]);
        end
        checks++;
        if (tc !== e[TW]) begin
          errors++;
          $display("FAIL %s tc: actual=%0b expected=%0b", tg, tc, e[TW]);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : driver
    // R1: reset state
    step(1, 0, "R1");
    step(1, 0, "R1");
    // R7: full range cascade, modulo 256
    for (int i = 0; i < 260; i++) step(0, 1, "R7");
    // R2: hold
    for (int i = 0; i < 4; i++) step(0, 0, "R2");
    // R1: clear beats enable
    step(1, 1, "R1");
    // R3: counting with a gappy enable
    for (int i = 0; i < 21; i++) step(0, (i % 3) != 0, "R3");
    // R6: terminal count at 255 needs the enable
    step(1, 0, "R1");
    for (int i = 0; i < 254; i++) step(0, 1, "R7");
    step(0, 1, "R6");
    step(0, 0, "R6");
    step(0, 1, "R6");
    // R9 then R4: 5..11 range on stage 0
    step(1, 0, "R1");
    lo_bound = 8'h05;
    hi_bound = 8'hFB;
    for (int i = 0; i < 12; i++) step(0, 1, "R9");
    for (int i = 0; i < 20; i++) step(0, 1, "R4");
    while (mq[W-1:0] != 4'd11) step(0, 1, "R4");
    // R10: pause at hi
    for (int i = 0; i < 3; i++) step(0, 0, "R10");
    step(0, 1, "R10");
    // R5: modulo 6 on stage 0
    step(1, 0, "R1");
    lo_bound = 8'h00;
    hi_bound = 8'hF5;
    for (int i = 0; i < 40; i++) step(0, 1, "R5");
    // R8: reversed bounds, plain modulo 16
    step(1, 0, "R1");
    lo_bound = 8'h09;
    hi_bound = 8'hF3;
    for (int i = 0; i < 40; i++) step(0, 1, "R8");
    repeat (2) @(posedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule